// File: doc/BRIEF.md
# Performance Monitor Counter Unit

The unit keeps six 32-bit event counters that software uses to profile a processor core. Every clock it receives the number of instructions retired in that cycle (0 to 8) and a run-state flag from the core. A control register and an event-select register decide, counter by counter, whether a counter adds the retired-instruction count, adds one per clock, or holds still. A set of freeze bits can stop all counters, or only one group of them.

Each counter can be armed to watch its sign bit. When an armed counter would reach or pass 0x8000_0000, it stops at exactly that value and raises a performance alert. The alert can set the global freeze bit. It can also turn a one-shot alert-enable bit into a sticky alert-occurred bit, and that bit drives the interrupt line. Software reads the counters and both registers through a combinational read port and writes them through a single write port.

Top module: `perf_mon_unit`

## Requirements
- R1: While control bit 0 (global freeze) is set, no counter changes except by a software write.
- R2: Counters 1 to 4 advance only while control bit 1 (freeze group 1-4) is clear, bit 0 is clear and the event-select register is nonzero. Counter k uses event-select bits [8k-1:8k-8].
- R3: Counter 1 adds the instruction count for codes 0x02 and 0xFE and adds one per clock for codes 0x1E and 0xF0. It holds for any other code.
- R4: Counters 2 and 3 add instructions for code 0x02 and one per clock for code 0x1E. Counter 4 adds one per clock for code 0x1E.
- R5: Counter 4 adds instructions for code 0x02 whatever the run flag is. For code 0xFA it adds instructions only while the run flag is high.
- R6: While control bits 0 and 2 (freeze group 5-6) are both clear, counter 5 adds the instruction count and counter 6 adds one per clock.
- R7: Control bit 3 arms counter 1 and control bit 4 arms counters 2 to 6. When an armed counter advances by a nonzero amount to a sum at or above 0x8000_0000, it is set to 0x8000_0000 and an alert fires. An unarmed counter wraps modulo 2^32.
- R8: On an alert, control bit 5 (freeze on alert) set causes bit 0 to be set. Control bit 6 (alert enable) set causes bit 6 to clear and bit 7 (alert occurred) to set, on the following clock edge.
- R9: The interrupt output equals control bit 7. That bit stays set until software writes the control register, and a software write sets or clears it directly.
- R10: Addresses 0 to 5 select counters 1 to 6, address 6 the control register (bits [7:0]) and address 7 the event-select register. A write takes effect at the next clock edge and overrides that register's own update in the same cycle. Reads are combinational.
- R11: After reset all counters and the event-select register are zero, the control register reads 0x01 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 32 | Read data for rd_addr_i |
| insn_cnt_i | input | 4 | Instructions retired this cycle (0 to 8) |
| run_i | input | 1 | Core run-state flag |
| alert_irq_o | output | 1 | Performance alert interrupt |

## Verification
The bench aims at the edges of event decoding. It uses the alternate codes for counter 1, an unmatched code, and counter 4's run-gated code with the run flag both low and high. A decoder that mixes up the codes shows a count that is off by a multiple of the instruction count. It drives an unarmed and an armed counter across the sign boundary. A missing clamp leaves 0x8000_0006 where 0x8000_0000 is expected, and a clamp that ignores the arm bit clips a counter that should have wrapped. It fires alerts with freeze-on-alert both set and clear and then rewrites the control register. A wrong alert update shows as a control value other than 0xB1 or 0x90, or as an interrupt that does not follow the software write. A counter written in a cycle where it also counts must hold the written value exactly.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NUM_CTR = 6;
  localparam int NUM_SEL = 4;

  localparam logic [7:0] CODE_INSN     = 8'h02;
  localparam logic [7:0] CODE_CYC      = 8'h1E;
  localparam logic [7:0] CODE_C1_INSN  = 8'hFE;
  localparam logic [7:0] CODE_C1_CYC   = 8'hF0;
  localparam logic [7:0] CODE_C4_RUN   = 8'hFA;

  typedef struct packed {
    logic alert_seen;   // bit 7
    logic alert_en;     // bit 6
    logic frz_on_alert; // bit 5
    logic arm_rest;     // bit 4
    logic arm_c1;       // bit 3
    logic frz_56;       // bit 2
    logic frz_14;       // bit 1
    logic frz_all;      // bit 0
  } pmu_ctrl_t;

  localparam pmu_ctrl_t CTRL_RST = 8'h01;
endpackage

// File: rtl/pmu_evt_decode.sv
module pmu_evt_decode
  import pmu_pkg::*;
#(
  parameter int INC_W = 4,
  parameter int EVT_W = 8
) (
  input  pmu_ctrl_t                        ctrl_i,
  input  logic [NUM_SEL*EVT_W-1:0]         evsel_i,
  input  logic [INC_W-1:0]                 insn_i,
  input  logic                             run_i,
  output logic [NUM_CTR-1:0][INC_W-1:0]    incr_o,
  output logic [NUM_CTR-1:0]               arm_o
);
  localparam logic [INC_W-1:0] ONE = INC_W'(1);

  logic [EVT_W-1:0] sel [NUM_SEL];
  logic grp_on, hi_on;

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_sel
    assign sel[k] = evsel_i[k*EVT_W +: EVT_W];
  end

  assign grp_on = !ctrl_i.frz_all && !ctrl_i.frz_14 && (|evsel_i);
  assign hi_on  = !ctrl_i.frz_all && !ctrl_i.frz_56;

  always_comb begin
    incr_o = '0;
    if (grp_on) begin
      if (sel[0] == EVT_W'(CODE_INSN) || sel[0] == EVT_W'(CODE_C1_INSN))
        incr_o[0] = insn_i;
      else if (sel[0] == EVT_W'(CODE_CYC) || sel[0] == EVT_W'(CODE_C1_CYC))
        incr_o[0] = ONE;
      for (int k = 1; k < 3; k++) begin
        if (sel[k] == EVT_W'(CODE_INSN))     incr_o[k] = insn_i;
        else if (sel[k] == EVT_W'(CODE_CYC)) incr_o[k] = ONE;
      end
      if (sel[3] == EVT_W'(CODE_INSN))        incr_o[3] = insn_i;
      else if (sel[3] == EVT_W'(CODE_C4_RUN)) incr_o[3] = run_i ? insn_i : '0;
      else if (sel[3] == EVT_W'(CODE_CYC))    incr_o[3] = ONE;
    end
    if (hi_on) begin
      incr_o[4] = insn_i;
      incr_o[5] = ONE;
    end
  end

  assign arm_o = {{(NUM_CTR-1){ctrl_i.arm_rest}}, ctrl_i.arm_c1};
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CTR_W = 32,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [CTR_W-1:0] wr_data_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             arm_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CTR_W:0] THR = (CTR_W+1)'(1) << (CTR_W-1);

  logic [CTR_W-1:0] cnt_q;
  logic [CTR_W:0]   sum;
  logic             adv;

  assign sum   = {1'b0, cnt_q} + (CTR_W+1)'(inc_i);
  assign adv   = (inc_i != '0);
  assign hit_o = !wr_en_i && adv && arm_i && (sum >= THR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_data_i;
    else if (hit_o)   cnt_q <= THR[CTR_W-1:0];
    else if (adv)     cnt_q <= sum[CTR_W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  pmu_ctrl_t wr_val_i,
  input  logic      alert_i,
  output pmu_ctrl_t ctrl_o
);
  pmu_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      ctrl_d = wr_val_i;
    end else if (alert_i) begin
      if (ctrl_q.frz_on_alert) ctrl_d.frz_all = 1'b1;
      if (ctrl_q.alert_en) begin
        ctrl_d.alert_en   = 1'b0;
        ctrl_d.alert_seen = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= CTRL_RST;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CTR_W  = 32,
  parameter int INC_W  = 4,
  parameter int EVT_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CTR_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CTR_W-1:0]  rd_data_o,
  input  logic [INC_W-1:0]  insn_cnt_i,
  input  logic              run_i,
  output logic              alert_irq_o
);
  localparam int SEL_W = NUM_SEL * EVT_W;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(NUM_CTR);
  localparam logic [ADDR_W-1:0] ADDR_EVSEL = ADDR_W'(NUM_CTR + 1);

  pmu_ctrl_t                      ctrl_q;
  logic [SEL_W-1:0]               evsel_q;
  logic [NUM_CTR-1:0][INC_W-1:0]  incr;
  logic [NUM_CTR-1:0]             arm;
  logic [NUM_CTR-1:0]             hit;
  logic [NUM_CTR-1:0][CTR_W-1:0]  ctr_q;
  logic                           any_hit;
  logic                           ctrl_we;

  assign ctrl_we = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign any_hit = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   evsel_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_EVSEL)   evsel_q <= wr_data_i[SEL_W-1:0];
  end

  pmu_evt_decode #(.INC_W(INC_W), .EVT_W(EVT_W)) u_dec (
    .ctrl_i  (ctrl_q),
    .evsel_i (evsel_q),
    .insn_i  (insn_cnt_i),
    .run_i   (run_i),
    .incr_o  (incr),
    .arm_o   (arm)
  );

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    pmu_counter #(.CTR_W(CTR_W), .INC_W(INC_W)) u_ctr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i && (wr_addr_i == ADDR_W'(k))),
      .wr_data_i (wr_data_i),
      .inc_i     (incr[k]),
      .arm_i     (arm[k]),
      .cnt_o     (ctr_q[k]),
      .hit_o     (hit[k])
    );
  end

  pmu_ctrl_reg u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (ctrl_we),
    .wr_val_i (pmu_ctrl_t'(wr_data_i[7:0])),
    .alert_i  (any_hit),
    .ctrl_o   (ctrl_q)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_CTRL)                  rd_data_o = CTR_W'(ctrl_q);
    else if (rd_addr_i == ADDR_EVSEL)            rd_data_o = CTR_W'(evsel_q);
    else if (int'(rd_addr_i) < NUM_CTR)          rd_data_o = ctr_q[rd_addr_i];
  end

  assign alert_irq_o = ctrl_q.alert_seen;
endmodule

// File: rtl/perf_mon_unit_chk.sv
module perf_mon_unit_chk
  import pmu_pkg::*;
#(
  parameter int CTR_W = 32
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input pmu_ctrl_t                     ctrl_q,
  input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q,
  input logic [NUM_CTR-1:0]            arm,
  input logic                          any_hit,
  input logic                          alert_irq_o
);
  localparam logic [CTR_W-1:0] THR = CTR_W'(1) << (CTR_W-1);

  assert_freeze_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.frz_all && !wr_en_i |=> ctr_q == $past(ctr_q));

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_clamp
    assert_clamp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(wr_en_i) && $past(arm[k]) && ($past(ctr_q[k]) <= THR) |-> ctr_q[k] <= THR);
  end

  assert_alert_converts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && any_hit && ctrl_q.alert_en |=> !ctrl_q.alert_en && ctrl_q.alert_seen);

  assert_freeze_on_alert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i && any_hit && ctrl_q.frz_on_alert |=> ctrl_q.frz_all);

  assert_irq_rise_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alert_irq_o) |-> $past(wr_en_i) || $past(ctrl_q.alert_en));

  assert_irq_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_irq_o && !wr_en_i |=> alert_irq_o);
endmodule

bind perf_mon_unit perf_mon_unit_chk #(.CTR_W(CTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .ctrl_q      (ctrl_q),
  .ctr_q       (ctr_q),
  .arm         (arm),
  .any_hit     (any_hit),
  .alert_irq_o (alert_irq_o)
);

// File: tb/perf_mon_unit_bench.sv
module perf_mon_unit_bench;
  typedef struct packed {
    logic [7:0]  ctrl;
    logic [31:0] evsel;
    logic [2:0]  idx;
    logic [31:0] preset;
    logic [3:0]  insn;
    logic        run;
    logic [7:0]  edges;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  // edges: clock edges with the vector's control value active (min 2)
  localparam vec_t VECS [NV] = '{
    '{8'h00, 32'h0000_0002, 3'd0, 32'd100,        4'd3, 1'b0, 8'd5, 32'd115,        8'd3}, // R3
    '{8'h00, 32'h0000_0000, 3'd5, 32'd7,          4'd0, 1'b0, 8'd4, 32'd11,         8'd6}, // R6
    '{8'h00, 32'h0000_1E00, 3'd1, 32'd0,          4'd5, 1'b0, 8'd6, 32'd6,          8'd4}, // R4
    '{8'h00, 32'hFA00_0000, 3'd3, 32'd10,         4'd4, 1'b0, 8'd5, 32'd10,         8'd5}, // R5
    '{8'h00, 32'hFA00_0000, 3'd3, 32'd10,         4'd4, 1'b1, 8'd5, 32'd30,         8'd5}, // R5
    '{8'h02, 32'h0000_0002, 3'd0, 32'd50,         4'd2, 1'b0, 8'd5, 32'd50,         8'd2}, // R2
    '{8'h04, 32'h0000_0000, 3'd4, 32'd9,          4'd2, 1'b0, 8'd4, 32'd9,          8'd6}, // R6
    '{8'h00, 32'h0002_0000, 3'd2, 32'd0,          4'd7, 1'b0, 8'd3, 32'd21,         8'd4}, // R4
    '{8'h00, 32'h0000_00FE, 3'd0, 32'd0,          4'd8, 1'b0, 8'd2, 32'd16,         8'd3}, // R3
    '{8'h00, 32'h0000_00F0, 3'd0, 32'd1,          4'd0, 1'b0, 8'd3, 32'd4,          8'd3}, // R3
    '{8'h00, 32'h0000_0000, 3'd4, 32'h7FFF_FFFE,  4'd4, 1'b0, 8'd2, 32'h8000_0006,  8'd7}, // R7
    '{8'h10, 32'h0000_0000, 3'd4, 32'h7FFF_FFFE,  4'd4, 1'b0, 8'd2, 32'h8000_0000,  8'd7}, // R7
    '{8'h00, 32'h0000_0055, 3'd0, 32'd3,          4'd2, 1'b0, 8'd4, 32'd3,          8'd3}, // R3
    '{8'h01, 32'h0000_0002, 3'd4, 32'd5,          4'd3, 1'b0, 8'd4, 32'd5,          8'd1}, // R1
    '{8'h00, 32'h0200_0000, 3'd3, 32'd0,          4'd3, 1'b0, 8'd4, 32'd12,         8'd5}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [3:0]  insn = '0;
  logic        run = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  perf_mon_unit u_perf_mon_unit (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .insn_cnt_i  (insn),
    .run_i       (run),
    .alert_irq_o (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int i = 0; i < 6; i++) begin
      rd(3'(i), v);
      check("R11", v, 32'd0);
    end
    rd(3'd6, v); check("R11", v, 32'h01);
    rd(3'd7, v); check("R11", v, 32'h00);
    check("R11", {31'd0, irq}, 32'd0);

    for (int n = 0; n < NV; n++) begin
      wr(3'd6, 32'h01);
      wr(3'd7, VECS[n].evsel);
      wr(VECS[n].idx, VECS[n].preset);
      insn = VECS[n].insn;
      run  = VECS[n].run;
      wr(3'd6, {24'd0, VECS[n].ctrl});
      repeat (int'(VECS[n].edges) - 2) @(negedge clk);
      wr(3'd6, 32'h01);
      rd(VECS[n].idx, v);
      check($sformatf("R%0d", VECS[n].req), v, VECS[n].expv);
    end

    // R8: alert with freeze-on-alert and alert enable
    wr(3'd6, 32'h01);
    wr(3'd7, 32'h0);
    wr(3'd4, 32'h7FFF_FFFF);
    insn = 4'd1; run = 1'b0;
    wr(3'd6, 32'h70);
    @(negedge clk);
    rd(3'd6, v); check("R8", v, 32'hB1);
    check("R9", {31'd0, irq}, 32'd1);
    rd(3'd4, v); check("R7", v, 32'h8000_0000);
    // R1: alert-induced freeze holds counter 6
    rd(3'd5, v);
    repeat (3) @(negedge clk);
    rd(3'd5, v2); check("R1", v2, v);

    // R8: alert without freeze-on-alert
    wr(3'd6, 32'h01);
    wr(3'd4, 32'h7FFF_FFFF);
    wr(3'd6, 32'h50);
    @(negedge clk);
    rd(3'd6, v); check("R8", v, 32'h90);
    check("R9", {31'd0, irq}, 32'd1);
    repeat (2) @(negedge clk);
    check("R9", {31'd0, irq}, 32'd1);

    // R9: software writes drive the interrupt
    wr(3'd6, 32'h01);
    check("R9", {31'd0, irq}, 32'd0);
    wr(3'd6, 32'h81);
    check("R9", {31'd0, irq}, 32'd1);
    wr(3'd6, 32'h01);
    check("R9", {31'd0, irq}, 32'd0);

    // R10: write beats increment in the same cycle
    insn = 4'd2;
    wr(3'd6, 32'h00);
    wr(3'd4, 32'h0000_1234);
    rd(3'd4, v); check("R10", v, 32'h0000_1234);
    @(negedge clk);
    rd(3'd4, v); check("R10", v, 32'h0000_1236);
    wr(3'd6, 32'h01);
    wr(3'd7, 32'hA5A5_1E02);
    rd(3'd7, v); check("R10", v, 32'hA5A5_1E02);

    finish_run();
  end
endmodule